// File: doc/BRIEF.md
# Monitor Channel Handshake Receiver

This block is the receiving side of a byte-wide monitor channel that is carried in a framed serial link. A single-cycle frame strobe marks the frame in which the incoming byte and its "A" (valid) bit can be sampled. The block drives back the "E" (acknowledge) bit, which takes effect at the next frame. A bit is active when it is 0. A new byte is present when A turns active after it was inactive in the frame before. The block places that byte in a receive register for the host and raises a one-cycle data-received interrupt.

The first byte of a message is acknowledged at once by pulling E low. After that, E stays low while the host holds an unread byte. Once the host has read the byte, at the next frame E is released high for exactly one frame and then pulled low again. The transmitter takes this as the acknowledge for the byte. When A stays inactive for two frames in a row during a message, the block raises a one-cycle end-of-reception interrupt. The host enables the block with a receive-enable input. Clearing that input holds E inactive for as long as it stays clear, which is how the receiver asks the transmitter to abort.

Top module: `mon_rx_top`

## Requirements
- R1: After reset, tx_e is 1, irq_rdy and irq_end are 0, and rd_data is 0.
- R2: A new byte is detected only in a frame where rx_a is 0 and rx_a was 1 in the previous frame. A second consecutive frame with rx_a at 0 is not a new byte.
- R3: A new byte that is accepted appears on rd_data, and irq_rdy is 1 for exactly the one cycle that follows the frame strobe.
- R4: When the block is enabled and no message is active, the first new byte drives tx_e to 0 from the cycle after its frame strobe.
- R5: During a message, the acknowledge for a later byte waits until the host has read the register with rd_stb. At the first frame after the read, tx_e goes to 1 for exactly one frame and returns to 0 at the following frame.
- R6: During a message, rx_a at 1 in two consecutive frames raises irq_end for one cycle and keeps tx_e at 0. Further inactive frames raise no further irq_end.
- R7: While rx_en is 0, no byte is stored and no interrupt is raised. From the first frame strobe with rx_en at 0, tx_e is 1 for every frame, and the message state is abandoned.
- R8: tx_e changes only in the cycle right after a frame strobe. Between strobes it is stable.
- R9: A byte that arrives while the previous byte is unread is not stored, and irq_rdy stays 0. Its acknowledge is held back until the host reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle strobe marking a frame |
| rx_a | input | 1 | Received A bit (0 = active) |
| rx_data | input | DATA_W | Received monitor byte |
| rx_en | input | 1 | Host receive enable |
| rd_stb | input | 1 | One-cycle host read of the receive register |
| rd_data | output | DATA_W | Receive register |
| tx_e | output | 1 | Outgoing E bit (0 = active) |
| irq_rdy | output | 1 | Data-received interrupt pulse |
| irq_end | output | 1 | End-of-reception interrupt pulse |

## Verification
Each result is due one cycle after the frame strobe that causes it. rd_data, tx_e and both interrupts settle in the cycle that follows the strobe. A read takes effect in the cycle after rd_stb, and its acknowledge appears only after the next strobe. The bench drives a strobe for one cycle, then samples all outputs at the falling edge of the following cycle. It samples again one cycle later to confirm that the interrupts have dropped and that tx_e has held its value.

// File: rtl/mon_rx_pkg.sv
package mon_rx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_PULSE = 2'd2,
      ST_DONE  = 2'd3
   } ack_st_t;
endpackage

// File: rtl/mon_a_track.sv
module mon_a_track #(
   parameter int END_FRAMES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_stb,
   input  logic rx_a,
   output logic new_byte,
   output logic end_hit
);
   logic a_prev_q;

   if (END_FRAMES < 2) begin : g_bad_end
      $error("END_FRAMES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         a_prev_q <= 1'b1;
      else if (frame_stb) a_prev_q <= rx_a;
   end

   assign new_byte = frame_stb && !rx_a && a_prev_q;

   if (END_FRAMES == 2) begin : g_end_pair
      assign end_hit = frame_stb && rx_a && a_prev_q;
   end else begin : g_end_count
      localparam int CNT_W = $clog2(END_FRAMES + 1);
      logic [CNT_W-1:0] idle_cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) idle_cnt_q <= '0;
         else if (frame_stb) begin
            if (!rx_a) idle_cnt_q <= '0;
            else if (idle_cnt_q != CNT_W'(END_FRAMES)) idle_cnt_q <= idle_cnt_q + 1'b1;
         end
      end
      assign end_hit = frame_stb && rx_a && (idle_cnt_q == CNT_W'(END_FRAMES - 1));
   end

   p_new_needs_prior_idle_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !rx_a) |=> !new_byte);
endmodule

// File: rtl/mon_rx_buf.sv
module mon_rx_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store,
   input  logic              rd_stb,
   input  logic [DATA_W-1:0] rx_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              full,
   output logic              irq_rdy
);
   if (DATA_W < 1) begin : g_bad_w
      $error("DATA_W must be positive");
   end

   logic [DATA_W-1:0] data_q;
   logic              full_q;
   logic              rdy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
         rdy_q  <= 1'b0;
      end else begin
         rdy_q <= store;
         if (store) begin
            data_q <= rx_data;
            full_q <= 1'b1;
         end else if (rd_stb) begin
            full_q <= 1'b0;
         end
      end
   end

   assign rd_data = data_q;
   assign full    = full_q;
   assign irq_rdy = rdy_q;

   p_store_flags_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      store |=> (full && irq_rdy));
   p_hold_unread_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_stb) |=> $stable(rd_data));
endmodule

// File: rtl/mon_ack_ctrl.sv
module mon_ack_ctrl
   import mon_rx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic frame_stb,
   input  logic rx_en,
   input  logic new_byte,
   input  logic end_hit,
   input  logic full,
   output logic store,
   output logic tx_e,
   output logic irq_end
);
   ack_st_t st_q;
   logic    pend_q;
   logic    end_q;
   logic    can_take;

   assign can_take = (st_q == ST_IDLE) || (st_q == ST_RUN);
   assign store    = rx_en && new_byte && can_take && !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pend_q <= 1'b0;
         end_q  <= 1'b0;
      end else begin
         end_q <= 1'b0;
         if (frame_stb) begin
            if (!rx_en) begin
               st_q   <= ST_IDLE;
               pend_q <= 1'b0;
            end else begin
               unique case (st_q)
                  ST_IDLE: if (new_byte) st_q <= ST_RUN;
                  ST_RUN: begin
                     if (end_hit) begin
                        st_q   <= ST_DONE;
                        end_q  <= 1'b1;
                        pend_q <= 1'b0;
                     end else if (pend_q && !full) begin
                        st_q   <= ST_PULSE;
                        pend_q <= 1'b0;
                     end else if (new_byte) begin
                        pend_q <= 1'b1;
                     end
                  end
                  ST_PULSE: st_q <= ST_RUN;
                  ST_DONE:  st_q <= ST_DONE;
                  default:  st_q <= ST_IDLE;
               endcase
            end
         end
      end
   end

   assign tx_e    = (st_q == ST_IDLE) || (st_q == ST_PULSE);
   assign irq_end = end_q;

   p_pulse_one_frame_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && rx_en && tx_e && (st_q == ST_PULSE)) |=> !tx_e);
   p_end_keeps_ack_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_end |-> !tx_e);
endmodule

// File: rtl/mon_rx_top.sv
module mon_rx_top #(
   parameter int DATA_W     = 8,
   parameter int END_FRAMES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              rx_a,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_en,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] rd_data,
   output logic              tx_e,
   output logic              irq_rdy,
   output logic              irq_end
);
   logic new_byte;
   logic end_hit;
   logic store;
   logic full;

   mon_a_track #(.END_FRAMES(END_FRAMES)) a_track_i (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_a(rx_a),
      .new_byte(new_byte), .end_hit(end_hit)
   );

   mon_ack_ctrl ack_ctrl_i (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_en(rx_en),
      .new_byte(new_byte), .end_hit(end_hit), .full(full),
      .store(store), .tx_e(tx_e), .irq_end(irq_end)
   );

   mon_rx_buf #(.DATA_W(DATA_W)) buf_i (
      .clk(clk), .rst_n(rst_n), .store(store), .rd_stb(rd_stb),
      .rx_data(rx_data), .rd_data(rd_data), .full(full), .irq_rdy(irq_rdy)
   );

   p_abort_idle_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !rx_en) |=> (tx_e && !irq_rdy && !irq_end));
   p_e_on_frame_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> $stable(tx_e));
   p_irq_excl_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_rdy && irq_end));
endmodule

// File: tb/mon_rx_top_tb_top.sv
module mon_rx_top_tb_top;
   localparam int DW = 8;
   localparam int NV = 23;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_stb = 1'b0;
   logic          rx_a = 1'b1;
   logic [DW-1:0] rx_data = '0;
   logic          rx_en = 1'b0;
   logic          rd_stb = 1'b0;
   logic [DW-1:0] rd_data;
   logic          tx_e, irq_rdy, irq_end;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mon_rx_top #(.DATA_W(DW), .END_FRAMES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_a(rx_a),
      .rx_data(rx_data), .rx_en(rx_en), .rd_stb(rd_stb),
      .rd_data(rd_data), .tx_e(tx_e), .irq_rdy(irq_rdy), .irq_end(irq_end)
   );

   // {req[3:0], rd, en, a, data[7:0], exp_e, exp_rdy, exp_end, exp_q[7:0]}
   function automatic logic [25:0] vec(input logic [3:0] req, input logic rd, input logic en,
      input logic a, input logic [7:0] d, input logic e, input logic rdy, input logic fin,
      input logic [7:0] q);
      return {req, rd, en, a, d, e, rdy, fin, q};
   endfunction

   localparam logic [25:0] VECS [NV] = '{
      vec(4'd2, 0,1,1,8'h00, 1,0,0,8'h00), // R2 idle, no byte
      vec(4'd4, 0,1,0,8'hA1, 0,1,0,8'hA1), // R4 R3 first byte acked at once
      vec(4'd2, 0,1,0,8'hA1, 0,0,0,8'hA1), // R2 A held low is not new
      vec(4'd6, 0,1,1,8'hA1, 0,0,0,8'hA1), // R6 one idle frame only
      vec(4'd9, 0,1,0,8'hB2, 0,0,0,8'hA1), // R9 unread: dropped
      vec(4'd9, 0,1,0,8'hB2, 0,0,0,8'hA1), // R9 ack held
      vec(4'd5, 1,1,0,8'hB2, 1,0,0,8'hA1), // R5 read then E pulse
      vec(4'd5, 0,1,0,8'hB2, 0,0,0,8'hA1), // R5 E back low
      vec(4'd2, 0,1,1,8'hC3, 0,0,0,8'hA1), // R2
      vec(4'd3, 0,1,0,8'hC3, 0,1,0,8'hC3), // R3 later byte stored
      vec(4'd5, 0,1,0,8'hC3, 0,0,0,8'hC3), // R5 no ack before read
      vec(4'd5, 1,1,0,8'hC3, 1,0,0,8'hC3), // R5 pulse
      vec(4'd5, 0,1,0,8'hC3, 0,0,0,8'hC3), // R5
      vec(4'd6, 0,1,1,8'hC3, 0,0,0,8'hC3), // R6 first idle frame
      vec(4'd6, 0,1,1,8'hC3, 0,0,1,8'hC3), // R6 end of reception
      vec(4'd6, 0,1,1,8'hC3, 0,0,0,8'hC3), // R6 no repeat
      vec(4'd7, 0,0,1,8'hC3, 1,0,0,8'hC3), // R7 disable
      vec(4'd7, 0,0,0,8'hD4, 1,0,0,8'hC3), // R7 byte ignored
      vec(4'd7, 0,0,1,8'hD4, 1,0,0,8'hC3), // R7
      vec(4'd4, 0,1,1,8'hD4, 1,0,0,8'hC3), // R4 re-enabled idle
      vec(4'd4, 0,1,0,8'hE5, 0,1,0,8'hE5), // R4 new first byte
      vec(4'd7, 0,0,0,8'hE5, 1,0,0,8'hE5), // R7 abort
      vec(4'd7, 0,0,0,8'hE5, 1,0,0,8'hE5)  // R7 E inactive second frame
   };

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "tx_e", 32'(tx_e), 32'd1);
      chk("R1", "irq_rdy", 32'(irq_rdy), 32'd0);
      chk("R1", "irq_end", 32'(irq_end), 32'd0);
      chk("R1", "rd_data", 32'(rd_data), 32'd0);
      rst_n = 1'b1;
      rx_en = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [25:0] v;
         string rq;
         logic e_now;
         v  = VECS[i];
         rq = $sformatf("R%0d", v[25:22]);
         if (v[21]) begin
            rd_stb = 1'b1;
            @(negedge clk);
            rd_stb = 1'b0;
            @(negedge clk);
         end
         rx_en     = v[20];
         rx_a      = v[19];
         rx_data   = v[18:11];
         frame_stb = 1'b1;
         @(negedge clk);
         frame_stb = 1'b0;
         chk(rq, "tx_e", 32'(tx_e), 32'(v[10]));
         chk(rq, "irq_rdy", 32'(irq_rdy), 32'(v[9]));
         chk(rq, "irq_end", 32'(irq_end), 32'(v[8]));
         chk(rq, "rd_data", 32'(rd_data), 32'(v[7:0]));
         e_now = tx_e;
         @(negedge clk);
         // R3 R6 pulses last one cycle; R8 E steady between frames
         chk("R3", "irq_rdy drop", 32'(irq_rdy), 32'd0);
         chk("R6", "irq_end drop", 32'(irq_end), 32'd0);
         chk("R8", "tx_e steady", 32'(tx_e), 32'(e_now));
         @(negedge clk);
      end

      // R8: input changes and a read without a strobe leave tx_e alone
      rx_en = 1'b1;
      rx_a  = 1'b1;
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      chk("R8", "tx_e no strobe", 32'(tx_e), 32'd1);
      rx_a = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8", "tx_e no strobe 2", 32'(tx_e), 32'd1);
      chk("R7", "irq_rdy quiet", 32'(irq_rdy), 32'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule